// File: doc/BRIEF.md
# Character-Line Raster Timing Counter

This block derives the raster timing of a character-cell CRT terminal from a single character-time strobe. A column counter steps through the character slots of each line. A line counter steps through the text rows, and one extra counted row, the last one, carries no video and serves as vertical retrace. The drive pulses and the frame marker are decoded from fixed character positions around that retrace row. No separate sync counters are used.

The surrounding display logic supplies a free-running clock, a synchronous reset and a one-clock strobe once per character time. It reads back the column and line numbers to address the character cell. It forwards the two active-low drive pulses to the sweep circuits and gates video with the blanking flag. The start-of-frame marker tells it that the first character of the first line is next. Every output is a register that updates only in clocks where the strobe is high. All pins are plain level signals with no handshake: the strobe is the only pacing input, and it cannot be stalled.

Defaults: 88 character slots per line, the line advance at slot 80, 14 counted rows (13 shown plus the retrace row), a horizontal drive pulse of 4 character times, and the marker at slot 87.

Top module: `raster_timing`

## Requirements
- R1: While `rst` is high at a clock edge, the block loads column 1, line 1, `vdrv_n`=1, `hdrv_n`=1, `blank`=0 and `sof`=0, even if `chr_stb` is high in the same clock.
- R2: Each clock with `chr_stb` high moves the column up by one. From the last slot (COLS) it moves to 1.
- R3: The line number moves up by one on the strobe taken while the column equals ADV_COL, and at no other time. From line LINES it moves to line 1.
- R4: `vdrv_n` is 0 exactly while the line number equals LINES (the retrace row). It falls on the strobe that enters that row and rises on the strobe that leaves it.
- R5: `hdrv_n` falls on the strobe that leaves the retrace row. It stays 0 for HD_LEN strobes, so it is low while the line is 1 and the column is in ADV_COL+1 to ADV_COL+HD_LEN. Otherwise it is 1.
- R6: `sof` is 1 for exactly one character time, while the line is 1 and the column equals MARK_COL after the retrace row has been left. It is 0 at all other times, including line 1 column MARK_COL-less positions of a fresh reset.
- R7: `blank` is 1 exactly when `vdrv_n` or `hdrv_n` is 0.
- R8: In clocks with `chr_stb` low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chr_stb | input | 1 | One-clock character-time strobe |
| col_o | output | $clog2(COLS+1) | Current character column, 1 to COLS |
| line_o | output | $clog2(LINES+1) | Current line number, 1 to LINES |
| vdrv_n | output | 1 | Vertical drive, active low |
| hdrv_n | output | 1 | Horizontal drive, active low |
| blank | output | 1 | Video blanking flag |
| sof | output | 1 | Start-of-frame marker, one character time |

## Verification
The counters are driven in two ways. First, the strobe is high on every clock for more than two whole frames, so every column and row position and two retrace rows are visited back to back. Second, the strobe comes only every third clock, which tells apart logic that counts clocks from logic that counts strobes and shows whether outputs hold steady in the gaps. Expected column, line, drive, blank and marker values are worked out from the number of strobes since reset. A reset applied mid-frame with the strobe held high shows that reset wins over a simultaneous strobe.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // registered drive-side outputs of the raster counter
  typedef struct packed {
    logic vdrv_n;
    logic hdrv_n;
    logic blank;
    logic sof;
  } drive_t;

  localparam drive_t DRIVE_IDLE = '{vdrv_n: 1'b1, hdrv_n: 1'b1, blank: 1'b0, sof: 1'b0};

endpackage

// File: rtl/raster_col_counter.sv
module raster_col_counter #(
  parameter int COLS = 88,
  parameter int CW   = $clog2(COLS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  output logic [CW-1:0] col
);
  localparam logic [CW-1:0] COL_FIRST = CW'(1);
  localparam logic [CW-1:0] COL_LAST  = CW'(COLS);

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= COL_FIRST;
    end else if (stb) begin
      if (col == COL_LAST) col <= COL_FIRST;
      else                 col <= col + CW'(1);
    end
  end
endmodule

// File: rtl/raster_line_counter.sv
module raster_line_counter #(
  parameter int LINES   = 14,
  parameter int ADV_COL = 80,
  parameter int CW      = 7,
  parameter int LW      = $clog2(LINES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic [CW-1:0] col,
  output logic [LW-1:0] line,
  output logic          enter_rt,
  output logic          leave_rt
);
  localparam logic [LW-1:0] LINE_FIRST = LW'(1);
  localparam logic [LW-1:0] LINE_RT    = LW'(LINES);
  localparam logic [LW-1:0] LINE_PRE   = LW'(LINES - 1);

  logic adv;

  assign adv      = stb && (col == CW'(ADV_COL));
  assign enter_rt = adv && (line == LINE_PRE);
  assign leave_rt = adv && (line == LINE_RT);

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= LINE_FIRST;
    end else if (adv) begin
      if (line == LINE_RT) line <= LINE_FIRST;
      else                 line <= line + LW'(1);
    end
  end
endmodule

// File: rtl/raster_drive_gen.sv
module raster_drive_gen
  import raster_pkg::*;
#(
  parameter int HD_LEN   = 4,
  parameter int MARK_COL = 87,
  parameter int CW       = 7,
  parameter int LW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic          enter_rt,
  input  logic          leave_rt,
  input  logic [CW-1:0] col,
  input  logic [LW-1:0] line,
  output drive_t        drv
);
  localparam int HW = (HD_LEN < 2) ? 1 : $clog2(HD_LEN);

  logic [HW-1:0] hcnt;
  logic          vdrv_nx;
  logic          hdrv_nx;
  logic          sof_nx;

  // next-state decode, taken only on strobe clocks
  always_comb begin
    vdrv_nx = drv.vdrv_n;
    if (enter_rt)      vdrv_nx = 1'b0;
    else if (leave_rt) vdrv_nx = 1'b1;

    hdrv_nx = drv.hdrv_n;
    if (leave_rt)                       hdrv_nx = 1'b0;
    else if (!drv.hdrv_n && hcnt == '0) hdrv_nx = 1'b1;

    // the tail of line 1 past the advance column only follows retrace
    sof_nx = (col == CW'(MARK_COL - 1)) && (line == LW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv  <= DRIVE_IDLE;
      hcnt <= '0;
    end else if (stb) begin
      drv.vdrv_n <= vdrv_nx;
      drv.hdrv_n <= hdrv_nx;
      drv.blank  <= !vdrv_nx || !hdrv_nx;
      drv.sof    <= sof_nx;
      if (leave_rt)                   hcnt <= HW'(HD_LEN - 1);
      else if (!drv.hdrv_n && hcnt != '0) hcnt <= hcnt - HW'(1);
    end
  end
endmodule

// File: rtl/raster_timing.sv
module raster_timing
  import raster_pkg::*;
#(
  parameter int COLS     = 88,
  parameter int ADV_COL  = 80,
  parameter int LINES    = 14,
  parameter int HD_LEN   = 4,
  parameter int MARK_COL = 87,
  localparam int CW      = $clog2(COLS + 1),
  localparam int LW      = $clog2(LINES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chr_stb,
  output logic [CW-1:0] col_o,
  output logic [LW-1:0] line_o,
  output logic          vdrv_n,
  output logic          hdrv_n,
  output logic          blank,
  output logic          sof
);
  logic   enter_rt;
  logic   leave_rt;
  drive_t drv;

  raster_col_counter #(.COLS(COLS), .CW(CW)) u_col (
    .clk (clk),
    .rst (rst),
    .stb (chr_stb),
    .col (col_o)
  );

  raster_line_counter #(.LINES(LINES), .ADV_COL(ADV_COL), .CW(CW), .LW(LW)) u_line (
    .clk      (clk),
    .rst      (rst),
    .stb      (chr_stb),
    .col      (col_o),
    .line     (line_o),
    .enter_rt (enter_rt),
    .leave_rt (leave_rt)
  );

  raster_drive_gen #(.HD_LEN(HD_LEN), .MARK_COL(MARK_COL), .CW(CW), .LW(LW)) u_drv (
    .clk      (clk),
    .rst      (rst),
    .stb      (chr_stb),
    .enter_rt (enter_rt),
    .leave_rt (leave_rt),
    .col      (col_o),
    .line     (line_o),
    .drv      (drv)
  );

  assign vdrv_n = drv.vdrv_n;
  assign hdrv_n = drv.hdrv_n;
  assign blank  = drv.blank;
  assign sof    = drv.sof;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int COLS     = 88,
  parameter int ADV_COL  = 80,
  parameter int LINES    = 14,
  parameter int MARK_COL = 87,
  parameter int CW       = 7,
  parameter int LW       = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          chr_stb,
  input logic [CW-1:0] col_o,
  input logic [LW-1:0] line_o,
  input logic          vdrv_n,
  input logic          hdrv_n,
  input logic          blank,
  input logic          sof
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (col_o == CW'(1) && line_o == LW'(1) && vdrv_n && hdrv_n && !blank && !sof));

  // R2
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (chr_stb && col_o != CW'(COLS)) |=> col_o == $past(col_o) + CW'(1));

  // R2
  col_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (chr_stb && col_o == CW'(COLS)) |=> col_o == CW'(1));

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(chr_stb && col_o == CW'(ADV_COL)) |=> $stable(line_o));

  // R4
  vdrv_row_chk: assert property (@(posedge clk) disable iff (rst)
    vdrv_n == (line_o != LW'(LINES)));

  // R5
  hdrv_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hdrv_n) |-> (line_o == LW'(1) && col_o == CW'(ADV_COL + 1)));

  // R6
  sof_place_chk: assert property (@(posedge clk) disable iff (rst)
    sof |-> (line_o == LW'(1) && col_o == CW'(MARK_COL)));

  // R7
  blank_mix_chk: assert property (@(posedge clk) disable iff (rst)
    blank == (!vdrv_n || !hdrv_n));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !chr_stb |=> ($stable(col_o) && $stable(line_o) && $stable(vdrv_n) &&
                  $stable(hdrv_n) && $stable(sof)));
endmodule

bind raster_timing raster_timing_chk #(
  .COLS(COLS), .ADV_COL(ADV_COL), .LINES(LINES), .MARK_COL(MARK_COL), .CW(CW), .LW(LW)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .chr_stb (chr_stb),
  .col_o   (col_o),
  .line_o  (line_o),
  .vdrv_n  (vdrv_n),
  .hdrv_n  (hdrv_n),
  .blank   (blank),
  .sof     (sof)
);

// File: tb/raster_timing_tb.sv
module raster_timing_tb_top;
  localparam int COLS     = 88;
  localparam int ADV_COL  = 80;
  localparam int LINES    = 14;
  localparam int HD_LEN   = 4;
  localparam int MARK_COL = 87;
  localparam int CW       = $clog2(COLS + 1);
  localparam int LW       = $clog2(LINES + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chr_stb = 1'b0;
  logic [CW-1:0] col_o;
  logic [LW-1:0] line_o;
  logic          vdrv_n, hdrv_n, blank, sof;

  int checks = 0;
  int errors = 0;
  int n_stb  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  raster_timing #(
    .COLS(COLS), .ADV_COL(ADV_COL), .LINES(LINES), .HD_LEN(HD_LEN), .MARK_COL(MARK_COL)
  ) dut_i (
    .clk(clk), .rst(rst), .chr_stb(chr_stb), .col_o(col_o), .line_o(line_o),
    .vdrv_n(vdrv_n), .hdrv_n(hdrv_n), .blank(blank), .sof(sof)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (strobes %0d)", tag, act, exp, n_stb);
    end
  endtask

  // expected outputs from strobe count since reset
  task automatic check_all(input bit gap);
    int ecol, eline, advs, ev, eh, es;
    ecol  = (n_stb % COLS) + 1;
    advs  = (n_stb + COLS - ADV_COL) / COLS;
    eline = (advs % LINES) + 1;
    ev    = (eline != LINES) ? 1 : 0;
    eh    = (eline == 1 && ecol > ADV_COL && ecol <= ADV_COL + HD_LEN) ? 0 : 1;
    es    = (eline == 1 && ecol == MARK_COL) ? 1 : 0;
    if (gap) begin
      chk("R8 col", int'(col_o), ecol);
      chk("R8 line", int'(line_o), eline);
      chk("R8 vdrv", int'(vdrv_n), ev);
      chk("R8 hdrv", int'(hdrv_n), eh);
      chk("R8 sof", int'(sof), es);
    end else begin
      chk("R2 col", int'(col_o), ecol);
      chk("R3 line", int'(line_o), eline);
      chk("R4 vdrv", int'(vdrv_n), ev);
      chk("R5 hdrv", int'(hdrv_n), eh);
      chk("R6 sof", int'(sof), es);
    end
    chk("R7 blank", int'(blank), (ev == 0 || eh == 0) ? 1 : 0);
  endtask

  task automatic check_reset();
    chk("R1 col", int'(col_o), 1);
    chk("R1 line", int'(line_o), 1);
    chk("R1 vdrv", int'(vdrv_n), 1);
    chk("R1 hdrv", int'(hdrv_n), 1);
    chk("R1 blank", int'(blank), 0);
    chk("R1 sof", int'(sof), 0);
  endtask

  task automatic tick(input bit s);
    chr_stb = s;
    @(posedge clk);
    @(negedge clk);
    if (s) n_stb++;
    check_all(!s);
  endtask

  initial begin
    int sofs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset();

    // pattern A: strobe every clock, over two frames
    sofs = 0;
    for (int i = 0; i < 2 * COLS * LINES + 100; i++) begin
      tick(1'b1);
      sofs += int'(sof);
    end
    chk("R6 sof count", sofs, 2);

    // pattern B: strobe every third clock, over one frame
    for (int i = 0; i < COLS * LINES + 40; i++) begin
      tick(1'b1);
      tick(1'b0);
      tick(1'b0);
    end

    // reset during retrace with a strobe in the same clock
    while (int'(line_o) != LINES) tick(1'b1);
    rst = 1'b1;
    chr_stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    chr_stb = 1'b0;
    n_stb = 0;
    for (int i = 0; i < 3 * COLS; i++) tick(1'b1);

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule